// File: doc/BRIEF.md
# Strobe-Handshake Control Register Target

This block is the responding side of a narrow control-register port. A host drives four strobe lines (load address, load data, commit, fetch) and a shared 16-bit input bus. The target keeps an address holding register and a write-data holding register. It also keeps a parameterised bank of 16-bit registers. Each accepted strobe is answered with a level acknowledge, and the host must see that acknowledge fall before it starts the next access.

A write takes three accesses. The host loads the address, loads the data, then commits. A read takes two: the host loads the address, then fetches, and the register value appears on the read bus for as long as acknowledge is high. The delay from a strobe edge to acknowledge is a parameter, so host-side timeout logic can be exercised. A build-time option removes acknowledge entirely.

All ports are plain control and data levels. There is no valid/ready stream here. Back-pressure is the four-phase rule itself: a strobe is held until acknowledge rises, and is then released. Acknowledge falls once the strobe is gone, and only then may another strobe rise.

Top module: `crp_target`

## Requirements
- R1: A rising load-address strobe (stb bit 0, `cap_addr_i`) latches `din_i` as the current address.
- R2: A rising load-data strobe (stb bit 1, `cap_data_i`) latches `din_i` into the write-data holding register and leaves every bank register unchanged.
- R3: A rising commit strobe (stb bit 2, `commit_i`) copies the held write data into the bank register at the current address.
- R4: A rising fetch strobe (stb bit 3, `fetch_i`) loads the bank register at the current address onto `rdata_o`. `rdata_o` keeps that value until the next accepted fetch.
- R5: Once `ack_o` is high, it stays high while the strobe that caused it stays high. It is low again at the first clock edge after that strobe is sampled low.
- R6: With latency parameter L (at least 1), `ack_o` goes high at the L-th clock edge after the edge that first samples the strobe high.
- R7: Bank registers occupy addresses 0 to DEPTH-1. A fetch from any address at or above DEPTH returns 0, and a commit to such an address changes nothing.
- R8: When more than one strobe is high at a sampling edge, no action is taken and no acknowledge is produced.
- R9: Reset clears the address register, the data holding register, every bank register, `rdata_o` and `ack_o`.
- R10: With the never-acknowledge option set, `ack_o` stays 0 for every strobe, while load, commit and fetch actions still take effect.
- R11: A strobe is acted on only on its rising edge while no handshake is in progress. A strobe that is still high when the target returns to idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_addr_i | input | 1 | Load-address strobe |
| cap_data_i | input | 1 | Load-data strobe |
| commit_i | input | 1 | Commit strobe |
| fetch_i | input | 1 | Fetch strobe |
| din_i | input | 16 | Address or write data from the host |
| ack_o | output | 1 | Four-phase acknowledge |
| rdata_o | output | 16 | Read data, valid while acknowledge is high after a fetch |

## Verification
The hardest case to reach from the ports is a strobe that overlaps another one, or that is still high when the target goes back to idle. A well-behaved host never produces either. The stimulus creates this case on purpose: it raises two strobes in the same cycle, then drops only one of them, and then issues a lone fetch. If the address register still holds the value it had before, the overlapping load was never acted on. Random mixes of writes and reads, including reads beyond the bank, are checked against a bench model of the register bank.

// File: rtl/crp_pkg.sv
`timescale 1ns/1ps
package crp_pkg;
  localparam int NSTB = 4;

  typedef enum logic [1:0] {
    K_ADDR   = 2'd0,
    K_DATA   = 2'd1,
    K_COMMIT = 2'd2,
    K_FETCH  = 2'd3
  } strobe_kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_HOLD = 2'd2
  } seq_state_e;
endpackage

// File: rtl/crp_strobe_front.sv
`timescale 1ns/1ps
module crp_strobe_front
  import crp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSTB-1:0] stb_i,
  input  logic            busy_i,
  output logic            start_o,
  output strobe_kind_e    kind_o
);
  logic [NSTB-1:0] prev_q;
  logic [NSTB-1:0] rise;
  logic            single;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stb_i;
  end

  assign rise   = stb_i & ~prev_q;
  assign single = $onehot(stb_i);

  // Only a lone strobe that has just risen while idle starts a handshake (R8, R11).
  assign start_o = !busy_i && single && (|rise);

  always_comb begin
    kind_o = K_ADDR;
    for (int i = 0; i < NSTB; i++) begin
      if (stb_i[i]) kind_o = strobe_kind_e'(i);
    end
  end
endmodule

// File: rtl/crp_ack_seq.sv
`timescale 1ns/1ps
module crp_ack_seq
  import crp_pkg::*;
#(
  parameter int ACK_LAT   = 2,
  parameter bit NEVER_ACK = 1'b0,
  localparam int CW = (ACK_LAT > 1) ? $clog2(ACK_LAT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSTB-1:0] stb_i,
  input  logic            start_i,
  input  strobe_kind_e    kind_i,
  output logic            busy_o,
  output logic            ack_o
);
  seq_state_e   state_q;
  logic [CW-1:0] cnt_q;
  strobe_kind_e kind_q;
  logic         lvl;

  assign lvl    = stb_i[kind_q];
  assign busy_o = (state_q != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      kind_q  <= K_ADDR;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_WAIT;
          cnt_q   <= CW'(ACK_LAT - 1);
          kind_q  <= kind_i;
        end
        S_WAIT: begin
          if (NEVER_ACK) begin
            if (!lvl) state_q <= S_IDLE;
          end else if (cnt_q == '0) begin
            state_q <= S_HOLD;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_HOLD: if (!lvl) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  generate
    if (NEVER_ACK) begin : g_silent
      assign ack_o = 1'b0;
    end else begin : g_ack
      assign ack_o = (state_q == S_HOLD);
    end
  endgenerate

  p_ack_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && !lvl) |=> !ack_o);
  p_ack_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && lvl) |=> ack_o);
  p_start_from_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (state_q == S_IDLE));
  p_no_instant_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !ack_o);
endmodule

// File: rtl/crp_reg_bank.sv
`timescale 1ns/1ps
module crp_reg_bank
  import crp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 16,
  parameter int DW    = 16,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  strobe_kind_e  kind_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] rdata_o
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] mem_q [DEPTH];
  logic          hit;
  logic [IW-1:0] idx;

  assign hit = ({1'b0, addr_q} < (AW+1)'(DEPTH));
  assign idx = addr_q[IW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_o <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (start_i) begin
      unique case (kind_i)
        K_ADDR:   addr_q  <= din_i[AW-1:0];
        K_DATA:   wdata_q <= din_i;
        K_COMMIT: if (hit) mem_q[idx] <= wdata_q;
        K_FETCH:  rdata_o <= hit ? mem_q[idx] : '0;
        default: ;
      endcase
    end
  end

  p_addr_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && kind_i == K_ADDR) |=> (addr_q == $past(din_i[AW-1:0])));
  p_data_keeps_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && kind_i == K_DATA) |=> $stable(addr_q));
  p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_i && kind_i == K_FETCH) |=> $stable(rdata_o));
endmodule

// File: rtl/crp_target.sv
`timescale 1ns/1ps
module crp_target
  import crp_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int ACK_LAT   = 2,
  parameter bit NEVER_ACK = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_addr_i,
  input  logic        cap_data_i,
  input  logic        commit_i,
  input  logic        fetch_i,
  input  logic [15:0] din_i,
  output logic        ack_o,
  output logic [15:0] rdata_o
);
  logic [NSTB-1:0] stb;
  logic            start;
  logic            busy;
  strobe_kind_e    kind;

  assign stb = {fetch_i, commit_i, cap_data_i, cap_addr_i};

  crp_strobe_front u_front (
    .clk(clk), .rst_n(rst_n), .stb_i(stb), .busy_i(busy),
    .start_o(start), .kind_o(kind)
  );

  crp_ack_seq #(.ACK_LAT(ACK_LAT), .NEVER_ACK(NEVER_ACK)) u_seq (
    .clk(clk), .rst_n(rst_n), .stb_i(stb), .start_i(start),
    .kind_i(kind), .busy_o(busy), .ack_o(ack_o)
  );

  crp_reg_bank #(.DEPTH(DEPTH), .AW(16), .DW(16)) u_bank (
    .clk(clk), .rst_n(rst_n), .start_i(start), .kind_i(kind),
    .din_i(din_i), .rdata_o(rdata_o)
  );

  p_conflict_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $countones(stb) > 1) |=> !busy);
endmodule

// File: tb/test_crp_target.sv
`timescale 1ns/1ps
module test_crp_target;
  localparam int DEPTH = 16;
  localparam int LAT   = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  stb = '0;
  logic [15:0] din = '0;
  logic        ack;
  logic [15:0] rdata;
  logic [3:0]  s_stb = '0;
  logic [15:0] s_din = '0;
  logic        s_ack;
  logic [15:0] s_rdata;

  always #2.5 clk = ~clk;

  crp_target #(.DEPTH(DEPTH), .ACK_LAT(LAT), .NEVER_ACK(1'b0)) i_crp_target (
    .clk(clk), .rst_n(rst_n), .cap_addr_i(stb[0]), .cap_data_i(stb[1]),
    .commit_i(stb[2]), .fetch_i(stb[3]), .din_i(din), .ack_o(ack), .rdata_o(rdata)
  );

  crp_target #(.DEPTH(DEPTH), .ACK_LAT(LAT), .NEVER_ACK(1'b1)) i_crp_target_silent (
    .clk(clk), .rst_n(rst_n), .cap_addr_i(s_stb[0]), .cap_data_i(s_stb[1]),
    .commit_i(s_stb[2]), .fetch_i(s_stb[3]), .din_i(s_din), .ack_o(s_ack), .rdata_o(s_rdata)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] mdl [DEPTH];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [15:0] a);
    return (a < DEPTH) ? mdl[a[3:0]] : 16'h0;
  endfunction

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // One four-phase access; returns cycles to ack, cycles to release, rdata at ack.
  task automatic access(input int k, input logic [15:0] d, input int hold,
                        output logic [15:0] rd, output int lat, output int rel, output bit held_ok);
    @(negedge clk);
    din = d;
    stb[k] = 1'b1;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!ack && lat < 60);
    rd = rdata;
    held_ok = 1'b1;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (!ack) held_ok = 1'b0;
    end
    stb[k] = 1'b0;
    rel = 0;
    do begin @(negedge clk); rel++; end while (ack && rel < 60);
  endtask

  task automatic write_reg(input logic [15:0] a, input logic [15:0] d);
    logic [15:0] rd; int l; int r; bit h;
    access(0, a, 0, rd, l, r, h);
    access(1, d, 0, rd, l, r, h);
    access(2, 16'h0, 0, rd, l, r, h);
    if (a < DEPTH) mdl[a[3:0]] = d;
  endtask

  task automatic read_reg(input logic [15:0] a, output logic [15:0] v);
    int l; int r; bit h;
    access(0, a, 0, v, l, r, h);
    access(3, 16'h0, 0, v, l, r, h);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    int lat; int rel; bit held;
    bit any_ack;
    void'($urandom(32'd4711));
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    chk(ack == 1'b0, "R9 ack in reset", ack, 0);
    chk(rdata == 16'h0, "R9 rdata in reset", rdata, 0);
    rst_n = 1'b1;

    // R6/R5: latency and release timing on a load-address strobe held 3 extra cycles.
    access(0, 16'h0005, 3, v, lat, rel, held);
    chk(lat == LAT + 1, "R6 ack latency", lat, LAT + 1);
    chk(held, "R5 ack held while strobe high", held, 1);
    chk(rel == 1, "R5 ack release after strobe drop", rel, 1);
    access(3, 16'h0, 0, v, lat, rel, held);
    chk(v == 16'h0, "R9 bank cleared after reset", v, 0);

    // R1/R3: write then read.
    write_reg(16'h0003, 16'hA5A5);
    read_reg(16'h0003, v);
    chk(v == 16'hA5A5, "R3 commit stores data", v, 16'hA5A5);
    write_reg(16'h000F, 16'h0F0F);
    read_reg(16'h000F, v);
    chk(v == 16'h0F0F, "R1 last address decoded", v, 16'h0F0F);

    // R2: a load-data alone must not touch the bank.
    access(0, 16'h0003, 0, v, lat, rel, held);
    access(1, 16'h1234, 0, v, lat, rel, held);
    access(3, 16'h0, 0, v, lat, rel, held);
    chk(v == 16'hA5A5, "R2 load-data leaves bank", v, 16'hA5A5);

    // R7: out-of-range address.
    write_reg(16'h0013, 16'hFFFF);
    read_reg(16'h0013, v);
    chk(v == 16'h0, "R7 unimplemented reads zero", v, 0);
    read_reg(16'h0003, v);
    chk(v == 16'hA5A5, "R7 aliased write dropped", v, 16'hA5A5);

    // R4: rdata holds after a non-fetch access.
    access(0, 16'h000F, 0, v, lat, rel, held);
    chk(rdata == 16'hA5A5, "R4 rdata held", rdata, 16'hA5A5);
    access(0, 16'h0003, 0, v, lat, rel, held);

    // R8/R11: two strobes together, then one left high.
    @(negedge clk);
    din = 16'h000F;
    stb = 4'b0011;
    any_ack = 1'b0;
    repeat (8) begin @(negedge clk); if (ack) any_ack = 1'b1; end
    chk(!any_ack, "R8 conflicting strobes not acknowledged", any_ack, 0);
    stb = 4'b0001;
    any_ack = 1'b0;
    repeat (6) begin @(negedge clk); if (ack) any_ack = 1'b1; end
    chk(!any_ack, "R11 leftover strobe ignored", any_ack, 0);
    stb = 4'b0000;
    repeat (2) @(negedge clk);
    access(3, 16'h0, 0, v, lat, rel, held);
    chk(v == 16'hA5A5, "R8 address not loaded by conflict", v, 16'hA5A5);

    // Random mix against the bench model (R3, R7).
    for (int n = 0; n < 300; n++) begin
      logic [15:0] a;
      logic [15:0] d;
      a = ($urandom % 8 == 0) ? 16'($urandom) : 16'($urandom % DEPTH);
      d = 16'($urandom);
      if ($urandom % 2 == 0) begin
        write_reg(a, d);
      end else begin
        read_reg(a, v);
        chk(v == exp_rd(a), "R3 R7 random read", v, exp_rd(a));
      end
    end

    // R10: never-acknowledge build still performs the actions.
    any_ack = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      s_din = (k == 0 || k == 2) ? 16'h0006 : 16'h0077;
      s_stb = '0;
      s_stb[(k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 2 : 3] = 1'b1;
      repeat (6) begin @(negedge clk); if (s_ack) any_ack = 1'b1; end
      s_stb = '0;
      repeat (2) @(negedge clk);
    end
    chk(!any_ack, "R10 no acknowledge", any_ack, 0);
    s_din = 16'h0006;
    s_stb = 4'b0001;
    repeat (4) @(negedge clk);
    s_stb = 4'b0000;
    repeat (2) @(negedge clk);
    s_stb = 4'b1000;
    repeat (4) @(negedge clk);
    s_stb = 4'b0000;
    repeat (2) @(negedge clk);
    chk(s_rdata == 16'h0077, "R10 actions still applied", s_rdata, 16'h0077);

    // R9: reset in the middle of operation.
    write_reg(16'h0002, 16'hBEEF);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(ack == 1'b0 && rdata == 16'h0, "R9 reset clears outputs", {ack, rdata}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    access(3, 16'h0, 0, v, lat, rel, held);
    chk(v == 16'h0, "R9 address cleared to zero", v, 0);
    read_reg(16'h0002, v);
    chk(v == 16'h0, "R9 bank cleared", v, 0);

    finish_run();
  end
endmodule